// File: doc/BRIEF.md
# Single-Accumulator Program Sequencer

This block is a minimal 8-bit processor that runs a fixed program. The program sits in a built-in read-only store of sixteen instruction words, and those words are fixed when the block is instantiated. After reset the block executes one instruction on every clock edge. Each instruction combines the accumulator with an 8-bit immediate using one of four operations. The result goes back into the accumulator.

After the instruction at the last address has retired, a two-state controller leaves its run state and enters a halt state. In the halt state the program counter and the accumulator no longer change. The accumulator, the program counter and a halted flag are brought out so that a surrounding design, or a bench, can watch the program execute.

An active-low clear drives all state to zero at once, with no clock needed. Its release passes through a two-flop synchronizer, so the first instruction executes on a known clock edge after release.

Top module: `acc_cpu`

## Requirements
- R1: Each instruction word is 10 bits wide. Bits [9:8] are the opcode: 00 ADD, 01 SUB, 10 OR, 11 AND. Bits [7:0] are the immediate. Word i of the program sits at bits [i*10 +: 10] of the PROGRAM parameter.
- R2: ADD writes (acc + imm) mod 256 into the accumulator.
- R3: SUB writes acc + ~imm + 1 mod 256 into the accumulator, so a borrow wraps to the top of the range.
- R4: OR and AND write the bitwise OR and the bitwise AND of acc and imm into the accumulator.
- R5: In the run state, exactly one instruction retires on each rising clock edge, and the program counter advances by one each time.
- R6: Once the instruction at address 15 has retired, halted_o is 1 and pc_o stays at 15. From then on the accumulator holds its value on every later edge.
- R7: When rst_n goes low, pc_o, acc_o and halted_o become 0 at once, without a clock edge.
- R8: Release of rst_n is synchronized through two flops. The first instruction retires on the third rising edge after rst_n goes high.
- R9: A clear applied mid-run or while halted restarts execution from address 0 in the run state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low clear, asserted asynchronously |
| pc_o | output | ADDR_W (4) | Address of the next instruction to execute |
| acc_o | output | DATA_W (8) | Accumulator contents |
| halted_o | output | 1 | High once the program has run to its end |

## Verification
The bench builds the block with the default 8-bit data width and 4-bit address width. It passes its own PROGRAM value, a sixteen-word program that uses all four opcodes. That program drives an addition past 255, a subtraction below zero, and an AND and an OR whose results differ from both operands. The bench checks every retired instruction, the transition into halt and the holding behaviour after it. It also applies the clear in the middle of a run and again while halted, so the asynchronous clear and the synchronized release can each be seen at the ports.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int unsigned OP_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_OR  = 2'b10,
    OP_AND = 2'b11
  } op_e;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HALT = 1'b1
  } ctrl_state_e;
endpackage

// File: rtl/acc_rst_sync.sv
module acc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/acc_rom.sv
module acc_rom #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned WORD_W = 10,
  parameter logic [(2**ADDR_W)*WORD_W-1:0] CONTENTS = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] word
);
  localparam int unsigned DEPTH = 2**ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign mem[i] = CONTENTS[i*WORD_W +: WORD_W];
  end

  assign word = mem[addr];
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_cpu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a + ~b + DATA_W'(1);
      OP_OR:   y = a | b;
      OP_AND:  y = a & b;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_cpu_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] pc,
  output logic              exec_en,
  output logic              halted
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

  ctrl_state_e       state_q, state_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              pc_en;

  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    pc_en   = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (pc_q == LAST_ADDR) begin
          state_d = ST_HALT;
        end else begin
          pc_en = 1'b1;
          pc_d  = pc_q + ADDR_W'(1);
        end
      end
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  assign pc      = pc_q;
  assign exec_en = (state_q == ST_RUN);
  assign halted  = (state_q == ST_HALT);
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4,
  parameter logic [(2**ADDR_W)*(DATA_W+2)-1:0] PROGRAM = {
    10'b10_1000_0001, 10'b00_0000_0001, 10'b01_0000_0010, 10'b11_1111_0000,
    10'b00_0001_0001, 10'b10_0000_1000, 10'b01_0000_0001, 10'b00_0100_0000,
    10'b11_0011_1111, 10'b00_0000_0011, 10'b01_0001_0000, 10'b10_0101_0101,
    10'b00_1111_1111, 10'b11_1010_1010, 10'b01_0000_0100, 10'b00_0000_0101
  }
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              halted_o
);
  localparam int unsigned WORD_W = OP_W + DATA_W;

  logic              rst_int_n;
  logic [ADDR_W-1:0] pc;
  logic              exec_en;
  logic              halted;
  logic [WORD_W-1:0] rom_word;
  logic [WORD_W-1:0] ir_q;
  logic [DATA_W-1:0] acc_q, acc_d;
  op_e               cur_op;
  logic [DATA_W-1:0] cur_imm;

  acc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  acc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .pc      (pc),
    .exec_en (exec_en),
    .halted  (halted)
  );

  acc_rom #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .CONTENTS(PROGRAM)) u_rom (
    .addr (pc),
    .word (rom_word)
  );

  assign cur_op  = op_e'(rom_word[WORD_W-1 -: OP_W]);
  assign cur_imm = rom_word[DATA_W-1:0];

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .op (cur_op),
    .a  (acc_q),
    .b  (cur_imm),
    .y  (acc_d)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   ir_q <= '0;
    else if (exec_en) ir_q <= rom_word;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   acc_q <= '0;
    else if (exec_en) acc_q <= acc_d;
  end

  assign pc_o     = pc;
  assign acc_o    = acc_q;
  assign halted_o = halted;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                halted,
  input logic [ADDR_W-1:0]   pc,
  input logic [DATA_W-1:0]   acc,
  input logic [DATA_W+1:0]   ir,
  input logic [DATA_W+1:0]   rom_word
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  logic [1:0]        op;
  logic [DATA_W-1:0] imm;
  assign op  = rom_word[DATA_W+1:DATA_W];
  assign imm = rom_word[DATA_W-1:0];

  a_r5_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && pc != LAST) |=> (pc == $past(pc) + ADDR_W'(1)));

  a_r6_halt_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && pc == LAST) |=> (halted && pc == LAST));

  a_r6_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(acc) && $stable(pc)));

  a_r1_ir_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |=> (ir == $past(rom_word)));

  a_r2_add_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && op == 2'b00) |=> (DATA_W'(acc - $past(imm)) == $past(acc)));

  a_r3_sub_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && op == 2'b01) |=> (DATA_W'(acc + $past(imm)) == $past(acc)));
endmodule

bind acc_cpu acc_cpu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .halted   (halted),
  .pc       (pc),
  .acc      (acc_q),
  .ir       (ir_q),
  .rom_word (rom_word)
);

// File: tb/tb_acc_cpu.sv
module tb_acc_cpu;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned WORDS  = 16;

  // word 0 is the rightmost entry
  localparam logic [WORDS*10-1:0] PROG = {
    {2'b10, 8'hA8}, {2'b00, 8'hFF}, {2'b11, 8'hFF}, {2'b10, 8'h00},
    {2'b01, 8'h80}, {2'b00, 8'h33}, {2'b11, 8'hF0}, {2'b10, 8'h55},
    {2'b00, 8'h01}, {2'b01, 8'h01}, {2'b01, 8'hFD}, {2'b10, 8'hC1},
    {2'b11, 8'h3C}, {2'b01, 8'h10}, {2'b00, 8'h90}, {2'b00, 8'h7F}
  };

  logic              clk;
  logic              rst_n;
  logic [ADDR_W-1:0] pc_o;
  logic [DATA_W-1:0] acc_o;
  logic              halted_o;

  int n_tests = 0;
  int n_fail  = 0;

  acc_cpu #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PROGRAM(PROG)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc_o     (pc_o),
    .acc_o    (acc_o),
    .halted_o (halted_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] model_step(input logic [7:0] a, input int idx);
    logic [9:0] w;
    w = PROG[idx*10 +: 10];
    case (w[9:8])
      2'b00:   return 8'(a + w[7:0]);           // R2
      2'b01:   return 8'(a - w[7:0]);           // R3
      2'b10:   return a | w[7:0];               // R4
      default: return a & w[7:0];               // R4
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // drop clear at a negedge and check the async effect without an edge (R7)
  task automatic apply_clear();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R7", "pc on clear", int'(pc_o), 0);
    check("R7", "acc on clear", int'(acc_o), 0);
    check("R7", "halted on clear", int'(halted_o), 0);
    @(negedge clk);
  endtask

  // release at negedge; two synchronizer edges follow (R8)
  task automatic release_clear();
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R8", "pc after 1st edge", int'(pc_o), 0);
    check("R8", "acc after 1st edge", int'(acc_o), 0);
    @(posedge clk);
    @(negedge clk);
    check("R8", "pc after 2nd edge", int'(pc_o), 0);
    check("R8", "acc after 2nd edge", int'(acc_o), 0);
    check("R8", "halted after 2nd edge", int'(halted_o), 0);
  endtask

  // run n instructions, checking each retirement (R2..R6)
  task automatic run_steps(input int n, input string tag);
    logic [7:0] acc_m;
    acc_m = 8'h00;
    for (int k = 1; k <= n; k++) begin
      acc_m = model_step(acc_m, k - 1);
      @(posedge clk);
      @(negedge clk);
      check("R5", {tag, " acc step"}, int'(acc_o), int'(acc_m));
      if (k < WORDS) begin
        check("R5", {tag, " pc step"}, int'(pc_o), k);
        check("R6", {tag, " not yet halted"}, int'(halted_o), 0);
      end else begin
        check("R6", {tag, " pc at end"}, int'(pc_o), WORDS - 1);
        check("R6", {tag, " halted"}, int'(halted_o), 1);
      end
    end
  endtask

  task automatic test_full_run();
    apply_clear();
    release_clear();
    run_steps(WORDS, "full");
    // acc after step 2 wrapped (R2) and after step 3 borrowed (R3); final 0xAA
    check("R4", "final acc", int'(acc_o), 8'hAA);
  endtask

  task automatic test_halt_hold();
    for (int i = 0; i < 6; i++) begin
      @(posedge clk);
      @(negedge clk);
      check("R6", "hold acc", int'(acc_o), 8'hAA);
      check("R6", "hold pc", int'(pc_o), WORDS - 1);
      check("R6", "hold halted", int'(halted_o), 1);
    end
  endtask

  task automatic test_clear_mid_run();
    apply_clear();
    release_clear();
    run_steps(5, "part");
    apply_clear();
    release_clear();
    run_steps(WORDS, "R9 restart");
  endtask

  task automatic test_clear_from_halt();
    apply_clear();
    release_clear();
    check("R9", "run state after halt clear", int'(halted_o), 0);
    run_steps(3, "R9 from halt");
  endtask

  initial begin : watchdog
    #1_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R7", "reset pc", int'(pc_o), 0);
    check("R7", "reset acc", int'(acc_o), 0);
    check("R7", "reset halted", int'(halted_o), 0);
    test_full_run();
    test_halt_hold();
    test_clear_mid_run();
    test_clear_from_halt();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule